// File: doc/BRIEF.md
# Indexed Configuration Register Port Decoder

This block sits behind a byte-wide memory-mapped write path and turns a small window of offsets into several banks of indexed configuration registers. Five banks follow the usual two-offset scheme: software first writes a register number to the bank's index offset, then writes the value to the bank's data offset. The index stays latched, so repeated data writes go to the same register. A sixth bank, the attribute bank, uses one offset for both steps. An internal toggle decides whether a write at that offset is an index or a value. Reading a fixed status offset puts that toggle back to "expect index".

A colour palette port takes an entry number, followed by a red, green and blue byte at a second offset. When the third byte arrives, the whole entry is committed and the entry number advances by one. This lets software load consecutive entries without sending the number again. A single miscellaneous output byte is also held. Lookup ports let the surrounding logic read any stored bank register or palette entry combinationally.

The request channel uses valid/ready. A transfer happens on a rising edge where `bus_valid` and `bus_ready` are both high. `bus_ready` is low while reset is held and on the first edge after reset is released, and high from then on. While ready is low, the requester must keep its request stable and wait. Reads return no data; their only effect is the toggle clear described below.

Top module: `irp_decoder`

## Requirements
- R1: While reset is asserted, `bus_ready` is 0. After reset, `bus_ready` is 1 and stays 1. Reset clears `misc_out`, `video_en`, `attr_phase`, every index latch, the palette pointer and byte phase, and every stored register and palette entry, all to 0.
- R2: Each of the five indexed banks has its index at offset I and its data at I+1, with I = 0x7AC for lookup code 0, 0x7A0 for code 1, 0x7A8 for code 2, 0x79C for code 3 and 0x788 for code 4. A data write stores the byte in the register selected by the last index written to that bank.
- R3: The index latch of a bank does not advance. Two data writes after one index write both land in the same register, and neighbouring registers keep their values.
- R4: The attribute bank (lookup code 5) uses offset 0x780 for both steps. `attr_phase` is 0 when the next write there is an index and 1 when it is a value. Each accepted write at 0x780 inverts `attr_phase`. The register number is bits 4:0 of the index byte.
- R5: An accepted read of offset 0x7B4 sets `attr_phase` to 0. Reads of other offsets and writes to 0x7B4 leave it unchanged.
- R6: `video_en` equals bit 5 of the most recent attribute index byte.
- R7: A write to offset 0x784 loads `misc_out` on the accepting edge.
- R8: A write to 0x790 sets the palette entry number and restarts the byte phase. The next three writes to 0x791 are red, green and blue. The third write stores the entry, read back on `pal_lk_rgb` as red in bits 23:16, green in 15:8 and blue in 7:0.
- R9: After each commit, the entry number advances by one and wraps from 255 to 0.
- R10: A write to 0x790 in the middle of a colour triple discards the partial colour. The entry that was being written keeps its old value.
- R11: Writes to unmapped offsets, and any cycle without an accepted transfer, change no stored state and no output.
- R12: A store becomes visible on the lookup outputs right after the accepting edge. In the cycle of the write itself, the lookup still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request accepted on this edge when high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_wdata | input | DW | Write byte |
| misc_out | output | DW | Miscellaneous output byte |
| video_en | output | 1 | Video enable from attribute index bit 5 |
| attr_phase | output | 1 | Attribute toggle, 1 = next write is a value |
| lk_bank | input | 3 | Lookup bank code 0..5 |
| lk_idx | input | log2(BANK_DEPTH) | Lookup register number |
| lk_data | output | DW | Stored register value |
| pal_lk_idx | input | log2(PAL_DEPTH) | Palette lookup entry |
| pal_lk_rgb | output | 3*DW | Palette entry {red, green, blue} |

## Verification
A register write and a lookup of that same register can happen in the same clock cycle. The bench first parks the lookup on a register holding a known value. It then drives a data write to that register. Before the accepting edge it requires the old value on `lk_data`, and after the edge it requires the new one. A second overlap is a status read arriving while the attribute toggle expects a value. That read must win, so the next write at 0x780 is again taken as an index; the bench checks this through `attr_phase` and the register the following value lands in.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int NUM_IDX_BANKS = 5;
  localparam int LK_ATTR       = 5;

  localparam logic [11:0] OFS_ATTR     = 12'h780;
  localparam logic [11:0] OFS_ATTR_CLR = 12'h7B4;
  localparam logic [11:0] OFS_MISC     = 12'h784;
  localparam logic [11:0] OFS_PAL_SEL  = 12'h790;
  localparam logic [11:0] OFS_PAL_DAT  = 12'h791;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} pal_phase_t;

  // Index offset of each two-offset bank; its data offset is one above.
  function automatic logic [11:0] idx_port_ofs(input int b);
    case (b)
      0:       return 12'h7AC;
      1:       return 12'h7A0;
      2:       return 12'h7A8;
      3:       return 12'h79C;
      default: return 12'h788;
    endcase
  endfunction
endpackage

// File: rtl/irp_idx_bank.sv
module irp_idx_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          dat_we,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] lk_idx,
  output logic [DW-1:0] lk_data
);
  logic [IW-1:0] idx_q;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (idx_we) idx_q <= wdata[IW-1:0];
      if (dat_we) mem[idx_q] <= wdata;
    end
  end

  assign lk_data = mem[lk_idx];
endmodule

// File: rtl/irp_attr_port.sv
module irp_attr_port #(
  parameter int DW      = 8,
  parameter int DEPTH   = 32,
  parameter int VID_BIT = 5,
  localparam int IW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          clr_stb,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] lk_idx,
  output logic [DW-1:0] lk_data,
  output logic          phase,
  output logic          video_en
);
  logic tog_q, vid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      vid_q <= 1'b0;
    end else begin
      if (clr_stb)     tog_q <= 1'b0;
      else if (wr_stb) tog_q <= ~tog_q;
      if (wr_stb && !tog_q) vid_q <= wdata[VID_BIT];
    end
  end

  irp_idx_bank #(.DW(DW), .DEPTH(DEPTH)) u_file (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_we (wr_stb && !tog_q),
    .dat_we (wr_stb && tog_q),
    .wdata  (wdata),
    .lk_idx (lk_idx),
    .lk_data(lk_data)
  );

  assign phase    = tog_q;
  assign video_en = vid_q;
endmodule

// File: rtl/irp_palette.sv
module irp_palette
  import irp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 256,
  localparam int PW   = $clog2(DEPTH),
  localparam int EW   = 3 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic          dat_we,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] lk_idx,
  output logic [EW-1:0] lk_rgb
);
  logic [PW-1:0] ptr_q;
  pal_phase_t    ph_q;
  logic [DW-1:0] red_q, grn_q;
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ph_q  <= PH_RED;
      red_q <= '0;
      grn_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (sel_we) begin
      ptr_q <= wdata[PW-1:0];
      ph_q  <= PH_RED;
    end else if (dat_we) begin
      case (ph_q)
        PH_RED: begin red_q <= wdata; ph_q <= PH_GRN; end
        PH_GRN: begin grn_q <= wdata; ph_q <= PH_BLU; end
        PH_BLU: begin
          mem[ptr_q] <= {red_q, grn_q, wdata};
          ptr_q      <= ptr_q + 1'b1;
          ph_q       <= PH_RED;
        end
        default: ph_q <= PH_RED;
      endcase
    end
  end

  assign lk_rgb = mem[lk_idx];
endmodule

// File: rtl/irp_decoder.sv
module irp_decoder
  import irp_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 8,
  parameter int BANK_DEPTH = 256,
  parameter int ATTR_DEPTH = 32,
  parameter int PAL_DEPTH  = 256,
  localparam int IW        = $clog2(BANK_DEPTH),
  localparam int AIW       = $clog2(ATTR_DEPTH),
  localparam int PW        = $clog2(PAL_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   misc_out,
  output logic            video_en,
  output logic            attr_phase,
  input  logic [2:0]      lk_bank,
  input  logic [IW-1:0]   lk_idx,
  output logic [DW-1:0]   lk_data,
  input  logic [PW-1:0]   pal_lk_idx,
  output logic [3*DW-1:0] pal_lk_rgb
);
  logic rdy_q;
  logic wr_acc, rd_acc;
  logic [DW-1:0] misc_q;
  logic [DW-1:0] bank_lk [NUM_IDX_BANKS];
  logic [DW-1:0] attr_lk;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign bus_ready = rdy_q;
  assign wr_acc = bus_valid && rdy_q && bus_write;
  assign rd_acc = bus_valid && rdy_q && !bus_write;

  for (genvar b = 0; b < NUM_IDX_BANKS; b++) begin : g_bank
    localparam logic [AW-1:0] IA = AW'(idx_port_ofs(b));
    localparam logic [AW-1:0] DA = AW'(idx_port_ofs(b) + 12'd1);
    irp_idx_bank #(.DW(DW), .DEPTH(BANK_DEPTH)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_we (wr_acc && bus_addr == IA),
      .dat_we (wr_acc && bus_addr == DA),
      .wdata  (bus_wdata),
      .lk_idx (lk_idx),
      .lk_data(bank_lk[b])
    );
  end

  irp_attr_port #(.DW(DW), .DEPTH(ATTR_DEPTH)) u_attr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_acc && bus_addr == AW'(OFS_ATTR)),
    .clr_stb (rd_acc && bus_addr == AW'(OFS_ATTR_CLR)),
    .wdata   (bus_wdata),
    .lk_idx  (lk_idx[AIW-1:0]),
    .lk_data (attr_lk),
    .phase   (attr_phase),
    .video_en(video_en)
  );

  irp_palette #(.DW(DW), .DEPTH(PAL_DEPTH)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_we(wr_acc && bus_addr == AW'(OFS_PAL_SEL)),
    .dat_we(wr_acc && bus_addr == AW'(OFS_PAL_DAT)),
    .wdata (bus_wdata),
    .lk_idx(pal_lk_idx),
    .lk_rgb(pal_lk_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                                    misc_q <= '0;
    else if (wr_acc && bus_addr == AW'(OFS_MISC))  misc_q <= bus_wdata;
  end
  assign misc_out = misc_q;

  always_comb begin
    lk_data = '0;
    for (int b = 0; b < NUM_IDX_BANKS; b++)
      if (lk_bank == 3'(b)) lk_data = bank_lk[b];
    if (lk_bank == 3'(LK_ATTR)) lk_data = attr_lk;
  end
endmodule

// File: rtl/irp_checker.sv
module irp_checker
  import irp_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] misc_out,
  input logic          video_en,
  input logic          attr_phase
);
  logic acc_w, acc_r;
  assign acc_w = bus_valid && bus_ready && bus_write;
  assign acc_r = bus_valid && bus_ready && !bus_write;

  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> bus_ready);

  a_r4_attr_flip: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w && bus_addr == AW'(OFS_ATTR) |=> attr_phase != $past(attr_phase));

  a_r5_attr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    acc_r && bus_addr == AW'(OFS_ATTR_CLR) |=> !attr_phase);

  a_r11_attr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !((acc_w && bus_addr == AW'(OFS_ATTR)) || (acc_r && bus_addr == AW'(OFS_ATTR_CLR)))
    |=> $stable(attr_phase));

  a_r6_video_bit: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w && bus_addr == AW'(OFS_ATTR) && !attr_phase |=> video_en == $past(bus_wdata[5]));

  a_r7_misc_load: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w && bus_addr == AW'(OFS_MISC) |=> misc_out == $past(bus_wdata));

  a_r11_misc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_w && bus_addr == AW'(OFS_MISC)) |=> $stable(misc_out));
endmodule

bind irp_decoder irp_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_irp_decoder.sv
`timescale 1ns/1ps
module tb_irp_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_ready, video_en, attr_phase;
  logic [7:0] misc_out, lk_data;
  logic [2:0] lk_bank = '0;
  logic [7:0] lk_idx = '0, pal_lk_idx = '0;
  logic [23:0] pal_lk_rgb;

  always #2.5 clk = ~clk;

  irp_decoder dut (.*);

  int nvec = 0, nbad = 0;

  // Reference model, built from the requirements
  logic [7:0]  mbank [6][256];
  logic [7:0]  midx  [6];
  logic [23:0] mpal  [256];
  logic [7:0]  mptr, mr, mg, mmisc;
  int          mph;
  logic        mtog, mvid;

  typedef struct {int kind; int sel; int idx; logic [23:0] exp; string tag;} item_t;
  item_t sbq[$];
  item_t it;

  function automatic logic [11:0] iofs(input int b);
    case (b) 0: return 12'h7AC; 1: return 12'h7A0; 2: return 12'h7A8;
      3: return 12'h79C; default: return 12'h788; endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void mdl_apply(input bit w, input logic [11:0] a, input logic [7:0] d);
    if (w) begin
      for (int b = 0; b < 5; b++) begin
        if (a == iofs(b)) midx[b] = d;
        if (a == iofs(b) + 12'd1) mbank[b][midx[b]] = d;
      end
      if (a == 12'h780) begin
        if (!mtog) begin midx[5] = d; mvid = d[5]; mtog = 1'b1; end
        else begin mbank[5][midx[5] & 8'h1F] = d; mtog = 1'b0; end
      end
      if (a == 12'h784) mmisc = d;
      if (a == 12'h790) begin mptr = d; mph = 0; end
      if (a == 12'h791) begin
        if (mph == 0) begin mr = d; mph = 1; end
        else if (mph == 1) begin mg = d; mph = 2; end
        else begin mpal[mptr] = {mr, mg, d}; mptr = mptr + 8'd1; mph = 0; end
      end
    end else if (a == 12'h7B4) mtog = 1'b0;
  endfunction

  task automatic bus_op(input bit w, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    mdl_apply(w, a, d);
  endtask

  task automatic push(input int kind, input int sel, input int idx, input string tag);
    item_t x;
    x.kind = kind; x.sel = sel; x.idx = idx; x.tag = tag;
    case (kind)
      0: x.exp = {16'h0, mbank[sel][(sel == 5) ? (idx & 31) : idx]};
      1: x.exp = mpal[idx];
      2: x.exp = {16'h0, mmisc};
      3: x.exp = {23'h0, mvid};
      default: x.exp = {23'h0, mtog};
    endcase
    sbq.push_back(x);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(posedge clk);
  endtask

  // Monitor: pops expectations and compares against the outputs
  always @(negedge clk) begin
    if (sbq.size() != 0) begin
      it = sbq.pop_front();
      if (it.kind == 0) begin lk_bank = 3'(it.sel); lk_idx = 8'(it.idx); end
      if (it.kind == 1) pal_lk_idx = 8'(it.idx);
      #1;
      case (it.kind)
        0: chk(lk_data == it.exp[7:0], it.tag, lk_data, it.exp);
        1: chk(pal_lk_rgb == it.exp, it.tag, pal_lk_rgb, it.exp);
        2: chk(misc_out == it.exp[7:0], it.tag, misc_out, it.exp);
        3: chk(video_en == it.exp[0], it.tag, video_en, it.exp);
        default: chk(attr_phase == it.exp[0], it.tag, attr_phase, it.exp);
      endcase
    end
  end

  initial begin
    #1000000;
    nbad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 6; b++) begin
      midx[b] = '0;
      for (int i = 0; i < 256; i++) mbank[b][i] = '0;
    end
    for (int i = 0; i < 256; i++) mpal[i] = '0;
    mptr = '0; mr = '0; mg = '0; mmisc = '0; mph = 0; mtog = 1'b0; mvid = 1'b0;

    repeat (4) @(negedge clk);
    chk(bus_ready == 1'b0, "R1 ready in reset", bus_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk(bus_ready == 1'b1, "R1 ready after reset", bus_ready, 1);
    push(2, 0, 0, "R1 misc reset"); push(3, 0, 0, "R1 video reset");
    push(4, 0, 0, "R1 phase reset"); push(0, 2, 8'h7F, "R1 bank reset");
    push(0, 5, 0, "R1 attr reset"); push(1, 0, 8'h33, "R1 pal reset");
    drain();

    // R2: every indexed bank at its own offsets
    for (int b = 0; b < 5; b++) begin
      bus_op(1, iofs(b), 8'(b * 17 + 3));
      bus_op(1, iofs(b) + 12'd1, 8'(8'hA0 + b));
    end
    for (int b = 0; b < 5; b++) push(0, b, b * 17 + 3, "R2 bank store");
    push(0, 0, 20, "R2 other bank untouched");
    drain();

    // R3: index latch does not advance
    bus_op(1, 12'h7A8, 8'h30);
    bus_op(1, 12'h7A9, 8'h11);
    bus_op(1, 12'h7A9, 8'h22);
    push(0, 2, 8'h30, "R3 same register"); push(0, 2, 8'h31, "R3 neighbour");
    drain();

    // R4 and R6: attribute toggle, register number in low bits
    bus_op(1, 12'h780, 8'h23);
    push(4, 0, 0, "R4 phase after index"); push(3, 0, 0, "R6 video set");
    drain();
    bus_op(1, 12'h780, 8'h5A);
    push(4, 0, 0, "R4 phase after value"); push(0, 5, 3, "R4 attr store");
    drain();

    // R5: status read clears toggle; other read does not
    bus_op(1, 12'h780, 8'h01);
    bus_op(0, 12'h780, 8'h00);
    push(4, 0, 0, "R5 other read keeps phase"); push(3, 0, 0, "R6 video cleared");
    drain();
    bus_op(0, 12'h7B4, 8'h00);
    push(4, 0, 0, "R5 status read clears");
    drain();
    bus_op(1, 12'h780, 8'h04);
    bus_op(1, 12'h780, 8'h77);
    push(0, 5, 4, "R5 index restarts"); push(0, 5, 1, "R5 old index unused");
    drain();

    // R7: misc output
    bus_op(1, 12'h784, 8'hC7);
    push(2, 0, 0, "R7 misc load");
    drain();

    // R8 and R9: palette triples, auto-advance, wrap
    bus_op(1, 12'h790, 8'h05);
    bus_op(1, 12'h791, 8'h11); bus_op(1, 12'h791, 8'h22); bus_op(1, 12'h791, 8'h33);
    bus_op(1, 12'h791, 8'h44); bus_op(1, 12'h791, 8'h55); bus_op(1, 12'h791, 8'h66);
    push(1, 0, 5, "R8 pal entry"); push(1, 0, 6, "R9 pal advance");
    drain();
    bus_op(1, 12'h790, 8'hFF);
    for (int k = 0; k < 6; k++) bus_op(1, 12'h791, 8'(8'h80 + k));
    push(1, 0, 255, "R9 pal last"); push(1, 0, 0, "R9 pal wrap");
    drain();

    // R10: reselect mid-triple
    bus_op(1, 12'h790, 8'h0A);
    bus_op(1, 12'h791, 8'hEE);
    bus_op(1, 12'h790, 8'h0C);
    bus_op(1, 12'h791, 8'h01); bus_op(1, 12'h791, 8'h02); bus_op(1, 12'h791, 8'h03);
    push(1, 0, 10, "R10 abandoned entry"); push(1, 0, 12, "R10 new entry");
    drain();

    // R11: unmapped writes, status write, idle with write held
    bus_op(1, 12'h7AE, 8'h99);
    bus_op(1, 12'h7B4, 8'h99);
    bus_op(1, 12'h785, 8'h99);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b1; bus_addr = 12'h784; bus_wdata = 8'hEE;
    @(negedge clk);
    bus_write = 1'b0;
    push(2, 0, 0, "R11 misc untouched"); push(4, 0, 0, "R11 phase untouched");
    push(0, 0, 3, "R11 bank untouched");
    drain();

    // R12: write and lookup of the same register in one cycle
    bus_op(1, 12'h7AC, 8'h40);
    bus_op(1, 12'h7AD, 8'h11);
    push(0, 0, 8'h40, "R12 setup");
    drain();
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h7AD; bus_wdata = 8'h99;
    #1 chk(lk_data == 8'h11, "R12 old value in write cycle", lk_data, 8'h11);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    mdl_apply(1'b1, 12'h7AD, 8'h99);
    #1 chk(lk_data == 8'h99, "R12 new value after edge", lk_data, 8'h99);

    // R5 overlap: status read while toggle expects a value
    bus_op(1, 12'h780, 8'h06);
    bus_op(0, 12'h7B4, 8'h00);
    bus_op(1, 12'h780, 8'h07);
    bus_op(1, 12'h780, 8'h3C);
    push(0, 5, 7, "R5 read beats pending value"); push(0, 5, 6, "R5 stale index");
    drain();

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule